// File: doc/BRIEF.md
# Machine CSR File Unit

This block holds the machine-mode control and status registers of a small RISC-V-style core and carries out the six CSR access operations. Each access reads the addressed register and, in the same cycle, computes its replacement. The old value goes back to the pipeline at once, and the new value is stored at the next clock edge. Every access is therefore one indivisible read-modify-write. An access to an address that is not implemented, or an access with an undefined operation code, raises an illegal-access flag and changes nothing.

The unit also keeps the trap registers. A trap-entry strobe stores the faulting PC, the cause (bit 31 marks an interrupt) and the trap value. It saves the global interrupt enable into its previous-enable bit and then clears the global enable. A return strobe restores the enable from the saved bit and sets the saved bit to 1. The return address and the trap vector are driven out continuously. The vector is direct mode only. Interrupt-pending bits mirror three request pins and cannot be written by software.

Top module: `mcsr_file`

## Requirements
- R1: The operation code `acc_op_i` takes these values: 1 write, 2 set, 3 clear, 5 write-immediate, 6 set-immediate, 7 clear-immediate. Codes 0 and 4 are undefined.
- R2: While `acc_valid_i` is high and the access is legal, `rdata_o` shows the value the register held before the access, in the same cycle. A written value is visible from the next cycle.
- R3: Set ORs the source into the register. Clear ANDs the register with the inverted source. The immediate forms use the 5-bit `acc_imm_i` zero-extended as the source, and the other forms use `acc_rs1_i`.
- R4: A valid access to an address outside the seven in R6, or with code 0 or 4, drives `illegal_o` high and `rdata_o` to zero, and modifies no register. Without `acc_valid_i`, `illegal_o` is low and `rdata_o` is zero.
- R5: Set and clear with `acc_src_zero_i` high, and set-immediate and clear-immediate with a zero immediate, write nothing. The write and write-immediate forms always write.
- R6: The addresses are 0x300 status, 0x304 enable, 0x305 vector, 0x341 return PC, 0x342 cause, 0x343 trap value and 0x344 pending. In status, only bit 3 (global enable) and bit 7 (previous enable) exist. In enable, only bits 3, 7 and 11 exist. Missing bits read 0. The vector, return PC, cause and trap value registers hold all 32 bits.
- R7: On `trap_i`, the return PC takes `trap_pc_i` and the cause takes {`trap_irq_i`, `trap_code_i`}. The trap value takes `trap_val_i`. The previous enable takes the global enable, and the global enable is cleared.
- R8: On `mret_i`, the global enable takes the previous enable and the previous enable becomes 1. `mie_o` shows the global enable.
- R9: Pending bits 3, 7 and 11 equal `irq_i[0]`, `irq_i[1]` and `irq_i[2]` in the same cycle. Writes to the pending register are ignored.
- R10: `tvec_o` is the vector register with bits 1:0 forced to 0. `epc_o` is the return PC register.
- R11: When several requests come in one cycle, trap entry takes priority over return, and return takes priority over an access write. The losing updates are dropped, and the access still returns the old value.
- R12: After reset, every register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_valid_i | input | 1 | CSR access request |
| acc_op_i | input | 3 | Operation code |
| acc_addr_i | input | 12 | CSR address |
| acc_rs1_i | input | 32 | Register source value |
| acc_imm_i | input | 5 | Immediate source |
| acc_src_zero_i | input | 1 | Source register index is zero (write-suppress hint) |
| trap_i | input | 1 | Trap entry strobe |
| trap_irq_i | input | 1 | Trap is an interrupt |
| trap_code_i | input | 31 | Cause code |
| trap_pc_i | input | 32 | Faulting PC |
| trap_val_i | input | 32 | Trap value |
| mret_i | input | 1 | Return-from-trap strobe |
| irq_i | input | 3 | Request pins {external, timer, software} |
| rdata_o | output | 32 | Old CSR value |
| illegal_o | output | 1 | Illegal access |
| epc_o | output | 32 | Return PC |
| tvec_o | output | 32 | Trap vector, direct mode |
| mie_o | output | 1 | Global interrupt enable |

## Verification
`rdata_o` and `illegal_o` are combinational, so they are due in the same cycle as the access. Every register update, whether from an access, a trap or a return, is due one cycle later. The bench drives inputs on the falling edge and compares all outputs 1 ns later against a behavioural model. It advances that model only at the rising edge, from the inputs still held. Each register effect is therefore judged in the cycle after its cause, and each read result is judged in the cycle of the read.

// File: rtl/mcsr_pkg.sv
package mcsr_pkg;
  localparam int unsigned NREG = 7;

  localparam int unsigned I_STATUS = 0;
  localparam int unsigned I_ENABLE = 1;
  localparam int unsigned I_VECTOR = 2;
  localparam int unsigned I_RETPC  = 3;
  localparam int unsigned I_CAUSE  = 4;
  localparam int unsigned I_TVAL   = 5;
  localparam int unsigned I_PEND   = 6;

  localparam logic [1:0] KIND_WR  = 2'd1;
  localparam logic [1:0] KIND_SET = 2'd2;
  localparam logic [1:0] KIND_CLR = 2'd3;

  localparam int unsigned GIE_BIT  = 3;
  localparam int unsigned PGIE_BIT = 7;

  function automatic logic [11:0] csr_addr(int unsigned idx);
    case (idx)
      I_STATUS: csr_addr = 12'h300;
      I_ENABLE: csr_addr = 12'h304;
      I_VECTOR: csr_addr = 12'h305;
      I_RETPC:  csr_addr = 12'h341;
      I_CAUSE:  csr_addr = 12'h342;
      I_TVAL:   csr_addr = 12'h343;
      default:  csr_addr = 12'h344;
    endcase
  endfunction
endpackage

// File: rtl/mcsr_decode.sv
module mcsr_decode
  import mcsr_pkg::*;
(
  input  logic            valid_i,
  input  logic [2:0]      op_i,
  input  logic [11:0]     addr_i,
  output logic [NREG-1:0] sel_o,
  output logic            legal_o,
  output logic            illegal_o,
  output logic [1:0]      kind_o,
  output logic            imm_form_o
);
  logic hit;
  logic op_ok;

  for (genvar i = 0; i < NREG; i++) begin : g_sel
    assign sel_o[i] = (addr_i == csr_addr(i));
  end

  assign hit        = |sel_o;
  assign op_ok      = (op_i[1:0] != 2'b00);
  assign legal_o    = valid_i & hit & op_ok;
  assign illegal_o  = valid_i & ~(hit & op_ok);
  assign kind_o     = op_i[1:0];
  assign imm_form_o = op_i[2];
endmodule

// File: rtl/mcsr_alu.sv
module mcsr_alu
  import mcsr_pkg::*;
#(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned IMM_W = 5
) (
  input  logic [1:0]       kind_i,
  input  logic             imm_form_i,
  input  logic [XLEN-1:0]  rs1_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic             src_zero_i,
  input  logic [XLEN-1:0]  old_i,
  output logic [XLEN-1:0]  new_o,
  output logic             wr_o
);
  logic [XLEN-1:0] src;
  logic            no_src;

  assign src    = imm_form_i ? {{(XLEN-IMM_W){1'b0}}, imm_i} : rs1_i;
  assign no_src = imm_form_i ? (imm_i == '0) : src_zero_i;

  always_comb begin
    new_o = old_i;
    wr_o  = 1'b0;
    case (kind_i)
      KIND_WR:  begin new_o = src;           wr_o = 1'b1;    end
      KIND_SET: begin new_o = old_i | src;   wr_o = ~no_src; end
      KIND_CLR: begin new_o = old_i & ~src;  wr_o = ~no_src; end
      default:  ;
    endcase
  end
endmodule

// File: rtl/mcsr_store.sv
module mcsr_store
  import mcsr_pkg::*;
#(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned IRQ_N = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [NREG-1:0] sel_i,
  input  logic [XLEN-1:0] wdata_i,
  input  logic            trap_i,
  input  logic            trap_irq_i,
  input  logic [XLEN-2:0] trap_code_i,
  input  logic [XLEN-1:0] trap_pc_i,
  input  logic [XLEN-1:0] trap_val_i,
  input  logic            mret_i,
  input  logic [IRQ_N-1:0] irq_i,
  output logic [XLEN-1:0] rdata_o,
  output logic [XLEN-1:0] epc_o,
  output logic [XLEN-1:0] tvec_o,
  output logic            gie_o,
  output logic            pgie_o
);
  localparam int unsigned TOP_IRQ_BIT = 4 * (IRQ_N - 1) + 3;

  function automatic logic [XLEN-1:0] irq_mask();
    logic [XLEN-1:0] m;
    m = '0;
    for (int k = 0; k < IRQ_N; k++) m[4*k+3] = 1'b1;
    return m;
  endfunction

  localparam logic [XLEN-1:0] IRQ_MASK = irq_mask();

  logic            gie_q, pgie_q;
  logic [XLEN-1:0] enable_q, vector_q, retpc_q, cause_q, tval_q;
  logic [XLEN-1:0] pend_w, status_w;
  logic [XLEN-1:0] rv [NREG];

  initial begin
    if (TOP_IRQ_BIT >= XLEN) $error("IRQ_N too large for XLEN");
  end

  always_comb begin
    pend_w = '0;
    for (int k = 0; k < IRQ_N; k++) pend_w[4*k+3] = irq_i[k];
  end

  always_comb begin
    status_w           = '0;
    status_w[GIE_BIT]  = gie_q;
    status_w[PGIE_BIT] = pgie_q;
  end

  always_comb begin
    rv[I_STATUS] = status_w;
    rv[I_ENABLE] = enable_q;
    rv[I_VECTOR] = vector_q;
    rv[I_RETPC]  = retpc_q;
    rv[I_CAUSE]  = cause_q;
    rv[I_TVAL]   = tval_q;
    rv[I_PEND]   = pend_w;
  end

  // one-hot select: OR of gated entries
  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NREG; i++) rdata_o = rdata_o | (sel_i[i] ? rv[i] : '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gie_q    <= 1'b0;
      pgie_q   <= 1'b0;
      enable_q <= '0;
      vector_q <= '0;
      retpc_q  <= '0;
      cause_q  <= '0;
      tval_q   <= '0;
    end else if (trap_i) begin
      retpc_q <= trap_pc_i;
      cause_q <= {trap_irq_i, trap_code_i};
      tval_q  <= trap_val_i;
      pgie_q  <= gie_q;
      gie_q   <= 1'b0;
    end else if (mret_i) begin
      gie_q  <= pgie_q;
      pgie_q <= 1'b1;
    end else if (we_i) begin
      if (sel_i[I_STATUS]) begin
        gie_q  <= wdata_i[GIE_BIT];
        pgie_q <= wdata_i[PGIE_BIT];
      end
      if (sel_i[I_ENABLE]) enable_q <= wdata_i & IRQ_MASK;
      if (sel_i[I_VECTOR]) vector_q <= wdata_i;
      if (sel_i[I_RETPC])  retpc_q  <= wdata_i;
      if (sel_i[I_CAUSE])  cause_q  <= wdata_i;
      if (sel_i[I_TVAL])   tval_q   <= wdata_i;
    end
  end

  assign epc_o  = retpc_q;
  assign tvec_o = {vector_q[XLEN-1:2], 2'b00};
  assign gie_o  = gie_q;
  assign pgie_o = pgie_q;
endmodule

// File: rtl/mcsr_file.sv
module mcsr_file
  import mcsr_pkg::*;
#(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned IMM_W = 5,
  parameter int unsigned IRQ_N = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             acc_valid_i,
  input  logic [2:0]       acc_op_i,
  input  logic [11:0]      acc_addr_i,
  input  logic [XLEN-1:0]  acc_rs1_i,
  input  logic [IMM_W-1:0] acc_imm_i,
  input  logic             acc_src_zero_i,
  input  logic             trap_i,
  input  logic             trap_irq_i,
  input  logic [XLEN-2:0]  trap_code_i,
  input  logic [XLEN-1:0]  trap_pc_i,
  input  logic [XLEN-1:0]  trap_val_i,
  input  logic             mret_i,
  input  logic [IRQ_N-1:0] irq_i,
  output logic [XLEN-1:0]  rdata_o,
  output logic             illegal_o,
  output logic [XLEN-1:0]  epc_o,
  output logic [XLEN-1:0]  tvec_o,
  output logic             mie_o
);
  logic [NREG-1:0] sel;
  logic            legal;
  logic [1:0]      kind;
  logic            imm_form;
  logic [XLEN-1:0] old_val, new_val;
  logic            alu_wr;
  logic            st_mpie;

  mcsr_decode u_dec (
    .valid_i    (acc_valid_i),
    .op_i       (acc_op_i),
    .addr_i     (acc_addr_i),
    .sel_o      (sel),
    .legal_o    (legal),
    .illegal_o  (illegal_o),
    .kind_o     (kind),
    .imm_form_o (imm_form)
  );

  mcsr_alu #(.XLEN(XLEN), .IMM_W(IMM_W)) u_alu (
    .kind_i     (kind),
    .imm_form_i (imm_form),
    .rs1_i      (acc_rs1_i),
    .imm_i      (acc_imm_i),
    .src_zero_i (acc_src_zero_i),
    .old_i      (old_val),
    .new_o      (new_val),
    .wr_o       (alu_wr)
  );

  mcsr_store #(.XLEN(XLEN), .IRQ_N(IRQ_N)) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (legal & alu_wr),
    .sel_i       (sel),
    .wdata_i     (new_val),
    .trap_i      (trap_i),
    .trap_irq_i  (trap_irq_i),
    .trap_code_i (trap_code_i),
    .trap_pc_i   (trap_pc_i),
    .trap_val_i  (trap_val_i),
    .mret_i      (mret_i),
    .irq_i       (irq_i),
    .rdata_o     (old_val),
    .epc_o       (epc_o),
    .tvec_o      (tvec_o),
    .gie_o       (mie_o),
    .pgie_o      (st_mpie)
  );

  assign rdata_o = legal ? old_val : '0;
endmodule

// File: rtl/mcsr_file_chk.sv
module mcsr_file_chk #(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned IRQ_N = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             acc_valid_i,
  input logic [2:0]       acc_op_i,
  input logic [11:0]      acc_addr_i,
  input logic [4:0]       acc_imm_i,
  input logic             trap_i,
  input logic [XLEN-1:0]  trap_pc_i,
  input logic             mret_i,
  input logic [IRQ_N-1:0] irq_i,
  input logic [XLEN-1:0]  rdata_o,
  input logic             illegal_o,
  input logic [XLEN-1:0]  epc_o,
  input logic             mie_o,
  input logic             st_mpie
);
  logic [XLEN-1:0] exp_pend;
  always_comb begin
    exp_pend = '0;
    for (int k = 0; k < IRQ_N; k++) exp_pend[4*k+3] = irq_i[k];
  end

  a_r7_trap_epc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_i |=> epc_o == $past(trap_pc_i));

  a_r7_trap_gie_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_i |=> !mie_o && st_mpie == $past(mie_o));

  a_r8_mret_restore: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mret_i && !trap_i) |=> mie_o == $past(st_mpie) && st_mpie);

  a_r4_illegal_no_effect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (illegal_o && !trap_i && !mret_i) |=> $stable(epc_o) && $stable(mie_o) && $stable(st_mpie));

  a_r4_illegal_zero_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> rdata_o == '0);

  a_r5_zero_imm_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && acc_op_i[2] && acc_op_i[1] && acc_imm_i == 5'd0 && !trap_i && !mret_i)
      |=> $stable(epc_o) && $stable(mie_o) && $stable(st_mpie));

  a_r9_pend_mirror: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && acc_addr_i == 12'h344 && acc_op_i[1:0] != 2'b00) |-> rdata_o == exp_pend);
endmodule

bind mcsr_file mcsr_file_chk #(.XLEN(XLEN), .IRQ_N(IRQ_N)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .acc_valid_i (acc_valid_i),
  .acc_op_i    (acc_op_i),
  .acc_addr_i  (acc_addr_i),
  .acc_imm_i   (acc_imm_i),
  .trap_i      (trap_i),
  .trap_pc_i   (trap_pc_i),
  .mret_i      (mret_i),
  .irq_i       (irq_i),
  .rdata_o     (rdata_o),
  .illegal_o   (illegal_o),
  .epc_o       (epc_o),
  .mie_o       (mie_o),
  .st_mpie     (st_mpie)
);

// File: tb/mcsr_file_test.sv
`timescale 1ns/1ps
module mcsr_file_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        acc_valid_i = 1'b0;
  logic [2:0]  acc_op_i = '0;
  logic [11:0] acc_addr_i = '0;
  logic [31:0] acc_rs1_i = '0;
  logic [4:0]  acc_imm_i = '0;
  logic        acc_src_zero_i = 1'b0;
  logic        trap_i = 1'b0, trap_irq_i = 1'b0;
  logic [30:0] trap_code_i = '0;
  logic [31:0] trap_pc_i = '0, trap_val_i = '0;
  logic        mret_i = 1'b0;
  logic [2:0]  irq_i = '0;
  logic [31:0] rdata_o, epc_o, tvec_o;
  logic        illegal_o, mie_o;

  mcsr_file uut (.*);

  always #10 clk_i = ~clk_i;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  // reference state
  bit          m_gie, m_pgie;
  logic [31:0] m_en, m_vec, m_epc, m_cause, m_tval;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] m_read(logic [11:0] a, output bit hit);
    hit = 1;
    case (a)
      12'h300: m_read = (32'(m_pgie) << 7) | (32'(m_gie) << 3);
      12'h304: m_read = m_en;
      12'h305: m_read = m_vec;
      12'h341: m_read = m_epc;
      12'h342: m_read = m_cause;
      12'h343: m_read = m_tval;
      12'h344: m_read = {20'b0, irq_i[2], 3'b0, irq_i[1], 3'b0, irq_i[0], 3'b0};
      default: begin m_read = '0; hit = 0; end
    endcase
  endfunction

  task automatic m_update();
    bit hit, legal, wr;
    logic [31:0] old, src, nv;
    old   = m_read(acc_addr_i, hit);
    legal = acc_valid_i && hit && acc_op_i[1:0] != 0;
    src   = acc_op_i[2] ? {27'b0, acc_imm_i} : acc_rs1_i;
    wr    = 0;
    nv    = old;
    case (acc_op_i[1:0])
      2'd1: begin nv = src; wr = 1; end
      2'd2: begin nv = old | src;  wr = acc_op_i[2] ? acc_imm_i != 0 : !acc_src_zero_i; end
      2'd3: begin nv = old & ~src; wr = acc_op_i[2] ? acc_imm_i != 0 : !acc_src_zero_i; end
      default: ;
    endcase
    if (trap_i) begin
      m_epc = trap_pc_i; m_cause = {trap_irq_i, trap_code_i}; m_tval = trap_val_i;
      m_pgie = m_gie; m_gie = 0;
    end else if (mret_i) begin
      m_gie = m_pgie; m_pgie = 1;
    end else if (legal && wr) begin
      case (acc_addr_i)
        12'h300: begin m_gie = nv[3]; m_pgie = nv[7]; end
        12'h304: m_en = nv & 32'h888;
        12'h305: m_vec = nv;
        12'h341: m_epc = nv;
        12'h342: m_cause = nv;
        12'h343: m_tval = nv;
        default: ;
      endcase
    end
  endtask

  task automatic step(string tag);
    bit hit, legal, ill;
    logic [31:0] v;
    #1;
    v     = m_read(acc_addr_i, hit);
    legal = acc_valid_i && hit && acc_op_i[1:0] != 0;
    ill   = acc_valid_i && !(hit && acc_op_i[1:0] != 0);
    chk(tag, "rdata", rdata_o, legal ? v : 32'h0);
    chk(tag, "illegal", {31'b0, illegal_o}, {31'b0, ill});
    chk("R7", "epc", epc_o, m_epc);
    chk("R10", "tvec", tvec_o, {m_vec[31:2], 2'b00});
    chk("R8", "mie", {31'b0, mie_o}, {31'b0, m_gie});
    @(posedge clk_i);
    if (rst_ni) m_update();
    @(negedge clk_i);
  endtask

  task automatic acc(string tag, logic [2:0] op, logic [11:0] a, logic [31:0] rs1,
                     logic [4:0] imm, bit sz);
    acc_valid_i = 1; acc_op_i = op; acc_addr_i = a; acc_rs1_i = rs1;
    acc_imm_i = imm; acc_src_zero_i = sz;
    step(tag);
    acc_valid_i = 0; acc_src_zero_i = 0;
  endtask

  // pure read: set with zero-source hint
  task automatic rd(string tag, logic [11:0] a, logic [31:0] exp);
    acc_valid_i = 1; acc_op_i = 3'd2; acc_addr_i = a; acc_rs1_i = 32'hFFFF_FFFF;
    acc_src_zero_i = 1;
    #1 chk(tag, "direct", rdata_o, exp);
    step(tag);
    acc_valid_i = 0; acc_src_zero_i = 0;
  endtask

  initial begin
    m_gie = 0; m_pgie = 0; m_en = 0; m_vec = 0; m_epc = 0; m_cause = 0; m_tval = 0;
    @(negedge clk_i);
    step("R12");
    rst_ni = 1;
    // R12 reset contents
    rd("R12", 12'h300, 0); rd("R12", 12'h304, 0); rd("R12", 12'h305, 0);
    rd("R12", 12'h341, 0); rd("R12", 12'h342, 0); rd("R12", 12'h343, 0);
    rd("R12", 12'h344, 0);
    // R2 write returns old value, R10 vector masking
    acc("R2", 3'd1, 12'h305, 32'h8000_0013, 0, 0);
    rd("R2", 12'h305, 32'h8000_0013);
    chk("R10", "tvec", tvec_o, 32'h8000_0010);
    // R3 R6 set/clear on enable with field mask
    acc("R3", 3'd2, 12'h304, 32'h0000_FFFF, 0, 0);
    rd("R6", 12'h304, 32'h888);
    acc("R3", 3'd3, 12'h304, 32'h80, 0, 0);
    rd("R3", 12'h304, 32'h808);
    acc("R3", 3'd6, 12'h300, 0, 5'd8, 0);
    rd("R6", 12'h300, 32'h8);
    acc("R3", 3'd5, 12'h343, 32'hFFFF_FFFF, 5'h1F, 0);
    rd("R3", 12'h343, 32'h1F);
    // R5 suppressed writes
    acc("R5", 3'd7, 12'h300, 0, 5'd0, 0);
    acc("R5", 3'd3, 12'h300, 32'h8, 0, 1);
    rd("R5", 12'h300, 32'h8);
    acc("R5", 3'd1, 12'h342, 32'h0, 0, 1);
    rd("R5", 12'h342, 32'h0);
    // R4 illegal address and op codes
    acc("R4", 3'd1, 12'h301, 32'h1234, 0, 0);
    acc("R4", 3'd4, 12'h343, 32'h1234, 0, 0);
    acc("R4", 3'd0, 12'h305, 32'h1234, 0, 0);
    rd("R4", 12'h343, 32'h1F);
    rd("R4", 12'h305, 32'h8000_0013);
    // R9 pending read-only
    irq_i = 3'b101;
    acc("R9", 3'd1, 12'h344, 32'hFFFF_FFFF, 0, 0);
    rd("R9", 12'h344, 32'h808);
    irq_i = 3'b010;
    rd("R9", 12'h344, 32'h080);
    irq_i = 0;
    // R7 trap entry
    trap_i = 1; trap_irq_i = 1; trap_code_i = 31'd7; trap_pc_i = 32'h100; trap_val_i = 32'hDEAD;
    step("R7");
    trap_i = 0;
    rd("R7", 12'h341, 32'h100); rd("R7", 12'h342, 32'h8000_0007);
    rd("R7", 12'h343, 32'hDEAD); rd("R7", 12'h300, 32'h80);
    // R11 trap beats access write
    trap_i = 1; trap_irq_i = 0; trap_code_i = 31'd2; trap_pc_i = 32'h204; trap_val_i = 32'h0;
    acc("R11", 3'd1, 12'h341, 32'h5555_0000, 0, 0);
    trap_i = 0;
    rd("R11", 12'h341, 32'h204); rd("R11", 12'h342, 32'h2);
    // R8 return
    mret_i = 1; step("R8"); mret_i = 0;
    rd("R8", 12'h300, 32'h80);
    mret_i = 1; step("R8"); mret_i = 0;
    rd("R8", 12'h300, 32'h88);
    // R11 return beats status write
    mret_i = 1;
    acc("R11", 3'd3, 12'h300, 32'hFF, 0, 0);
    mret_i = 0;
    rd("R11", 12'h300, 32'h88);
    // R1 mixed traffic
    for (int i = 0; i < 400; i++) begin
      logic [11:0] al [8] = '{12'h300, 12'h304, 12'h305, 12'h341, 12'h342, 12'h343, 12'h344, 12'h7C0};
      acc_valid_i = ($urandom % 4) != 0;
      acc_op_i = 3'($urandom);
      acc_addr_i = al[$urandom % 8];
      acc_rs1_i = $urandom;
      acc_imm_i = ($urandom % 4 == 0) ? 5'd0 : 5'($urandom);
      acc_src_zero_i = ($urandom % 3) == 0;
      trap_i = ($urandom % 16) == 0;
      trap_irq_i = 1'($urandom);
      trap_code_i = 31'($urandom);
      trap_pc_i = $urandom;
      trap_val_i = $urandom;
      mret_i = ($urandom % 12) == 0;
      irq_i = 3'($urandom);
      step("R1");
    end
    acc_valid_i = 0; trap_i = 0; mret_i = 0;
    step("R1");
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule